// File: doc/BRIEF.md
# Shift-Based Spare Column Steering

This block sits between a memory client and a memory array that carries one spare column for each half of the data word. When a column of the array is known to be faulty, a small soft repair configuration names the bad column of each half. On the write path, every data bit at or above that position moves up one physical column, so the top bit of the half lands in that half's spare column. On the read path, the inverse move gathers the stored bits back into logical order and skips the faulty column.

Each half forms its own repair region. The low half of the logical word uses physical columns 0 to HALF_W. The high half uses physical columns HALF_W+1 to 2*HALF_W+1. The top column of each region is its spare. The steering is purely combinational. The repair settings live in registers that load on a clock edge, so a repair analyser can change them at run time without fuses.

Top module: `colshift_steer`

## Requirements
- R1: After reset both halves are unrepaired. The physical write word is the logical word placed straight into columns 0..HALF_W-1 of each region with both spare columns driven 0, and the read word is taken straight from those same columns.
- R2: On a rising clock edge with cfg_we_i high, the enable and index of both halves load from the configuration inputs. With cfg_we_i low, the settings in use stay unchanged whatever the configuration inputs do.
- R3: With a half's repair enabled and fault index f, that half's logical bit i drives region column i when i < f and region column i+1 when i >= f.
- R4: With a half enabled, its faulty region column f is driven 0. With a half disabled, its spare column is driven 0.
- R5: With a half enabled and fault index f, logical read bit i comes from region column i when i < f and from region column i+1 otherwise. The value returned by column f has no effect on rd_data_o.
- R6: The two halves are independent. The repair setting of one half changes no physical column of the other region and no logical bit of the other half.
- R7: When the array returns a constant value on each faulty column and stores the other columns faithfully, a word written and read back with matching repair settings is returned unchanged.
- R8: The boundary indices work. Index 0 shifts the whole half by one column. Index HALF_W-1 moves only the top bit of the half into the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the repair registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load strobe for both halves' repair settings |
| cfg_lo_en_i | input | 1 | Repair enable for the low half |
| cfg_lo_idx_i | input | 6 | Faulty column index within the low half |
| cfg_hi_en_i | input | 1 | Repair enable for the high half |
| cfg_hi_idx_i | input | 6 | Faulty column index within the high half |
| wr_data_i | input | 128 | Logical write word |
| arr_wdata_o | output | 130 | Physical word driven to the array columns |
| arr_rdata_i | input | 130 | Physical word returned by the array columns |
| rd_data_o | output | 128 | Logical read word |

## Verification
The hardest case to reach is a round trip through a genuinely broken column: data must reach the array, take damage at the faulty position, and still come back intact. The bench models a small array whose faulty columns are stuck at 0 or 1. Several words are written under one repair setting and read back under the same setting, so a miscount in either shifter shows up as a corrupted bit. Fault indices 0 and 63 in each half, and a repair enabled in one half only, test the region edges and the isolation between halves.

// File: rtl/colshift_pkg.sv
package colshift_pkg;
    // default number of data columns in one repair region
    localparam int DEF_HALF_W = 64;
    // number of repair regions in the word
    localparam int NUM_REGIONS = 2;

    // first physical column of a region (data columns plus one spare each)
    function automatic int region_base(input int region, input int half_w);
        return region * (half_w + 1);
    endfunction
endpackage

// File: rtl/colshift_cfg_reg.sv
module colshift_cfg_reg #(
    parameter int IW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic                 lo_en_i,
    input  logic [IW-1:0]        lo_idx_i,
    input  logic                 hi_en_i,
    input  logic [IW-1:0]        hi_idx_i,
    output logic [1:0]           en_o,
    output logic [1:0][IW-1:0]   idx_o
);
    typedef struct packed {
        logic [1:0]         en;
        logic [1:0][IW-1:0] idx;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.en  = {hi_en_i, lo_en_i};
            st_d.idx = {hi_idx_i, lo_idx_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign idx_o = st_q.idx;

    // R2: a strobed load takes the inputs seen at that edge
    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_o == $past({hi_en_i, lo_en_i}) && idx_o == $past({hi_idx_i, lo_idx_i})));

    // R2: without the strobe the settings hold
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(en_o) && $stable(idx_o)));
endmodule

// File: rtl/colshift_wr_half.sv
module colshift_wr_half #(
    parameter int W  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [IW-1:0] f_i,
    input  logic [W-1:0]  d_i,
    output logic [W:0]    p_o
);
    for (genvar j = 0; j <= W; j++) begin : g_col
        localparam int JJ = j;
        if (j == 0) begin : g_bot
            assign p_o[j] = (en_i && int'(f_i) == JJ) ? 1'b0 : d_i[j];
        end else if (j == W) begin : g_spare
            assign p_o[j] = (en_i && int'(f_i) < W) ? d_i[W-1] : 1'b0;
        end else begin : g_mid
            always_comb begin
                if (en_i && int'(f_i) < JJ)       p_o[j] = d_i[j-1];
                else if (en_i && int'(f_i) == JJ) p_o[j] = 1'b0;
                else                              p_o[j] = d_i[j];
            end
        end
    end

    // R4: the faulty column carries no data
    assert_fault_col_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (p_o[f_i] == 1'b0));

    // R4: an unused spare is held low
    assert_spare_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (p_o[W] == 1'b0));
endmodule

// File: rtl/colshift_rd_half.sv
module colshift_rd_half #(
    parameter int W  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [IW-1:0] f_i,
    input  logic [W:0]    p_i,
    output logic [W-1:0]  q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int II = i;
        assign q_o[i] = (en_i && int'(f_i) <= II) ? p_i[i+1] : p_i[i];
    end

    // R5: the top logical bit comes from the spare whenever repair is on
    assert_top_from_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && int'(f_i) < W) |-> (q_o[W-1] == p_i[W]));
endmodule

// File: rtl/colshift_steer.sv
module colshift_steer #(
    parameter int HALF_W = colshift_pkg::DEF_HALF_W,
    parameter int IDX_W  = $clog2(HALF_W),
    parameter int DATA_W = 2 * HALF_W,
    parameter int PHYS_W = 2 * (HALF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cfg_lo_en_i,
    input  logic [IDX_W-1:0]  cfg_lo_idx_i,
    input  logic              cfg_hi_en_i,
    input  logic [IDX_W-1:0]  cfg_hi_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [PHYS_W-1:0] arr_wdata_o,
    input  logic [PHYS_W-1:0] arr_rdata_i,
    output logic [DATA_W-1:0] rd_data_o
);
    import colshift_pkg::*;

    localparam int REG_W = HALF_W + 1;

    logic [1:0]            en_q;
    logic [1:0][IDX_W-1:0] idx_q;

    colshift_cfg_reg #(.IW(IDX_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .lo_en_i  (cfg_lo_en_i),
        .lo_idx_i (cfg_lo_idx_i),
        .hi_en_i  (cfg_hi_en_i),
        .hi_idx_i (cfg_hi_idx_i),
        .en_o     (en_q),
        .idx_o    (idx_q)
    );

    for (genvar h = 0; h < NUM_REGIONS; h++) begin : g_region
        localparam int PB = region_base(h, HALF_W);

        colshift_wr_half #(.W(HALF_W), .IW(IDX_W)) i_wr (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_q[h]),
            .f_i   (idx_q[h]),
            .d_i   (wr_data_i[h*HALF_W +: HALF_W]),
            .p_o   (arr_wdata_o[PB +: REG_W])
        );

        colshift_rd_half #(.W(HALF_W), .IW(IDX_W)) i_rd (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_q[h]),
            .f_i   (idx_q[h]),
            .p_i   (arr_rdata_i[PB +: REG_W]),
            .q_o   (rd_data_o[h*HALF_W +: HALF_W])
        );
    end

    // R7: a faithful loop-back through the array restores the logical word
    assert_round_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rdata_i == arr_wdata_o) |-> (rd_data_o == wr_data_i));
endmodule

// File: tb/test_colshift_steer.sv
module test_colshift_steer;
    localparam int HW = 64;
    localparam int IW = 6;
    localparam int DW = 2 * HW;
    localparam int PW = 2 * (HW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          lo_en = 1'b0, hi_en = 1'b0;
    logic [IW-1:0] lo_idx = '0, hi_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [PW-1:0] arr_wdata;
    logic [PW-1:0] arr_rdata;
    logic [DW-1:0] rd_data;

    logic [PW-1:0] mem [8];
    logic [2:0]    raddr = '0;
    logic          use_mem = 1'b0;
    logic [PW-1:0] ext_rdata = '0;
    logic [PW-1:0] stuck_mask = '0, stuck_val = '0;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign arr_rdata = use_mem ? ((mem[raddr] & ~stuck_mask) | (stuck_val & stuck_mask)) : ext_rdata;

    colshift_steer i_colshift_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_lo_en_i  (lo_en),
        .cfg_lo_idx_i (lo_idx),
        .cfg_hi_en_i  (hi_en),
        .cfg_hi_idx_i (hi_idx),
        .wr_data_i    (wr_data),
        .arr_wdata_o  (arr_wdata),
        .arr_rdata_i  (arr_rdata),
        .rd_data_o    (rd_data)
    );

    // model settings currently expected inside the design
    logic          m_en [2];
    int            m_f  [2];

    function automatic logic [PW-1:0] exp_wr(input logic [DW-1:0] d);
        logic [PW-1:0] p = '0;
        for (int h = 0; h < 2; h++) begin
            for (int j = 0; j <= HW; j++) begin
                int pb = h * (HW + 1) + j;
                if (!m_en[h])       p[pb] = (j < HW) ? d[h*HW + j] : 1'b0;
                else if (j < m_f[h]) p[pb] = d[h*HW + j];
                else if (j == m_f[h]) p[pb] = 1'b0;
                else                 p[pb] = d[h*HW + j - 1];
            end
        end
        return p;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [PW-1:0] p);
        logic [DW-1:0] q = '0;
        for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < HW; i++) begin
                int pb = h * (HW + 1) + i;
                q[h*HW + i] = (m_en[h] && i >= m_f[h]) ? p[pb + 1] : p[pb];
            end
        end
        return q;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic le, input int lf, input logic he, input int hf);
        @(negedge clk);
        lo_en = le; lo_idx = IW'(lf); hi_en = he; hi_idx = IW'(hf);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[0] = le; m_f[0] = lf; m_en[1] = he; m_f[1] = hf;
    endtask

    task automatic apply_wr(input string req, input logic [DW-1:0] d);
        wr_data = d;
        #1;
        check(req, arr_wdata, exp_wr(d));
    endtask

    task automatic apply_rd(input string req, input logic [PW-1:0] p);
        use_mem = 1'b0;
        ext_rdata = p;
        #1;
        check(req, PW'(rd_data), PW'(exp_rd(p)));
    endtask

    task automatic t_reset();
        m_en[0] = 1'b0; m_en[1] = 1'b0; m_f[0] = 0; m_f[1] = 0;
        @(negedge clk);
        apply_wr("R1 reset write", {DW{1'b1}});
        apply_wr("R1 reset write", rnd_word());
        apply_rd("R1 reset read", {PW{1'b1}});
    endtask

    task automatic t_write_map();
        load_cfg(1'b1, 5, 1'b1, 40);
        apply_wr("R3 write map", {DW{1'b1}});
        apply_wr("R3 write map", rnd_word());
        apply_wr("R4 faulty col zero", {DW{1'b1}});
        load_cfg(1'b1, 33, 1'b0, 0);
        apply_wr("R4 spare idle when off", {DW{1'b1}});
    endtask

    task automatic t_read_map();
        load_cfg(1'b1, 17, 1'b1, 2);
        for (int k = 0; k < 4; k++)
            apply_rd("R5 read map", {2'($urandom), rnd_word()});
        // flip only the faulty column of each region: read word must not change
        apply_rd("R5 faulty col ignored", '0);
        apply_rd("R5 faulty col ignored", (PW'(1) << 17) | (PW'(1) << (HW + 1 + 2)));
        check("R5 faulty col ignored", PW'(rd_data), '0);
    endtask

    task automatic t_cfg_hold();
        load_cfg(1'b1, 9, 1'b1, 50);
        @(negedge clk);
        lo_en = 1'b0; lo_idx = 6'd1; hi_en = 1'b0; hi_idx = 6'd60;
        @(negedge clk);
        @(negedge clk);
        apply_wr("R2 hold without strobe", rnd_word());
        apply_rd("R2 hold without strobe", {2'($urandom), rnd_word()});
    endtask

    task automatic t_independent();
        logic [PW-1:0] lo_before;
        load_cfg(1'b0, 0, 1'b0, 0);
        wr_data = rnd_word();
        #1;
        lo_before = arr_wdata;
        load_cfg(1'b0, 0, 1'b1, 0);
        #1;
        check("R6 low region untouched", PW'(arr_wdata[HW:0]), PW'(lo_before[HW:0]));
        apply_wr("R6 only high shifted", wr_data);
        apply_rd("R6 low read straight", {2'($urandom), rnd_word()});
    endtask

    task automatic t_boundary();
        load_cfg(1'b1, 0, 1'b1, HW - 1);
        apply_wr("R8 idx0 and top idx", rnd_word());
        apply_wr("R8 idx0 and top idx", {DW{1'b1}});
        apply_rd("R8 idx0 and top idx", {2'($urandom), rnd_word()});
        load_cfg(1'b1, HW - 1, 1'b1, 0);
        apply_wr("R8 swapped edges", rnd_word());
        apply_rd("R8 swapped edges", {2'($urandom), rnd_word()});
    endtask

    task automatic t_round_trip(input int lf, input int hf, input logic sv);
        logic [DW-1:0] words [8];
        load_cfg(1'b1, lf, 1'b1, hf);
        stuck_mask = (PW'(1) << lf) | (PW'(1) << (HW + 1 + hf));
        stuck_val  = sv ? stuck_mask : '0;
        for (int a = 0; a < 8; a++) begin
            words[a] = rnd_word();
            wr_data = words[a];
            #1;
            mem[a] = arr_wdata;
        end
        use_mem = 1'b1;
        for (int a = 0; a < 8; a++) begin
            raddr = 3'(a);
            #1;
            check("R7 round trip", PW'(rd_data), PW'(words[a]));
        end
        use_mem = 1'b0;
        stuck_mask = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_map();
        t_read_map();
        t_cfg_hold();
        t_independent();
        t_boundary();
        t_round_trip(7, 31, 1'b1);
        t_round_trip(0, HW - 1, 1'b0);
        t_round_trip(HW - 1, 0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule